// File: doc/BRIEF.md
# Multi-Mode Boot Memory Interface Controller

This block sits between the CPU's internal memory request path and external boot ROM or Flash parts. It accepts one request at a time: an address, a size of 1, 2 or 4 bytes, a write flag, write data and a burst flag for cache-line refills. It turns each request into one or more external bus transfers. The external side has three active-low region selects, one extra select for a card socket, a dedicated read strobe, a dedicated write strobe, a byte address within the region, and split data-in and data-out buses with an output enable.

The top address bits choose the region. Every region has its own configuration: bus width of 8, 16 or 32 bits, slow fixed-length timing or fast timing, a wait-state count and a write-protect bit. A burst request reads a whole 16-byte line. On an eligible region it uses page timing after the first beat. Writes into a protected region are dropped and leave a sticky flag. A strap pin or a control bit moves regions 0 and 1 onto the card-socket select.

Top module: `rom_flash_ctrl`

## Requirements
- R1: The two top address bits pick the region. Codes 0, 1 and 2 drive `rom_cs_n[code]` low for the whole access. Code 3 is unmapped: no select or strobe goes active, and `rsp_valid` comes up in the cycle after acceptance with zero data.
- R2: `cfg_width` holds a 2-bit field per region, with region r at bits [2r+1:2r]. The codes are 0 for 8-bit, 1 for 16-bit and 2 (or 3) for 32-bit, giving W bytes. An S-byte request (`req_size` 0/1/2 means 1/2/4 bytes) takes max(1, S/W) transfers. `rom_addr` advances by W between transfers. Each transfer's data comes from the low W lanes, is packed upward from byte 0, and bytes at or above S read as zero.
- R3: A slow region (`cfg_fast` bit clear) holds each transfer for 6 + wait clocks. The wait count is the 3-bit field `cfg_wait[3r+2:3r]`.
- R4: A fast region holds each transfer for 1 + wait clocks.
- R5: A burst read to a fast region of width 16 or 32 returns 16/W beats. The first beat lasts 1 + wait clocks and every later beat lasts 1 + `cfg_page_wait` clocks. `rsp_valid` pulses once per beat, with the beat's bytes in the low W lanes and zeros above. A burst flag on a write is ignored, and the write runs as a plain write.
- R6: A burst read to any other region also returns 16/W beats with one pulse each. Each beat is a full single transfer with the region's normal timing.
- R7: A write to a region whose `cfg_wp` bit is set drives no select and no strobe. It completes with `rsp_valid` in the cycle after acceptance and sets `wp_violation`, which stays set until reset. Reads of that region still run.
- R8: During an access exactly one strobe is low: `rom_rd_n` for reads, or `rom_wr_n` together with `rom_doe` for writes. Transfer i of a write drives request bytes [iW, iW+W) on the low lanes of `rom_dout`.
- R9: While `strap_remap` or `sw_remap` is high, accesses to regions 0 and 1 drive `card_cs_n` low and leave `rom_cs_n` high. Region 2 is unaffected.
- R10: `req_ready` is high only while no access is in flight. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Every `rsp_valid` pulse lasts one cycle, and a single access gives exactly one pulse.
- R11: After reset, `req_ready` is high, all selects and strobes are high, and `rsp_valid` and `wp_violation` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Region code in top bits, byte offset below |
| req_size | input | 2 | 0/1/2 = 1/2/4 bytes |
| req_burst | input | 1 | Cache-line refill request |
| req_wdata | input | 32 | Write data, byte 0 in low lane |
| rsp_valid | output | 1 | Completion or burst beat pulse |
| rsp_data | output | 32 | Read data for the pulse |
| cfg_width | input | 2*NREG | Per-region width code |
| cfg_fast | input | NREG | Per-region fast timing enable |
| cfg_wait | input | WAIT_W*NREG | Per-region wait states |
| cfg_page_wait | input | PAGE_W | Wait states of later burst beats |
| cfg_wp | input | NREG | Per-region write protect |
| strap_remap | input | 1 | Strap-selected card remap |
| sw_remap | input | 1 | Control-bit card remap |
| rom_cs_n | output | NREG | Region selects, active low |
| card_cs_n | output | 1 | Card-socket select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_wr_n | output | 1 | Write strobe, active low |
| rom_addr | output | ADDR_W-2 | Byte address inside the region |
| rom_dout | output | 32 | Write data to the bus |
| rom_doe | output | 1 | Drive enable for `rom_dout` |
| rom_din | input | 32 | Read data from the bus |
| wp_violation | output | 1 | Sticky protected-write flag |

## Verification
The bench goes after cycle counts by measuring the number of edges from acceptance to the last response. A miscounted wait field, a page wait applied to the first beat, or a slow base other than six clocks shows up as an off-by-N there. Narrow regions with multi-byte requests and odd addresses catch wrong address stepping or byte placement, which would duplicate or shift bytes. Bursts are run to an ineligible 8-bit region, so a design that applied page timing there would finish far too early. Burst-flagged writes are run as well, and a design that did not ignore the flag would return extra beats. Protected writes, unmapped addresses and both remap sources check that no strobe or wrong select leaks out and that the violation flag survives later traffic.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    localparam int RFC_DATA_W     = 32;
    localparam int RFC_LINE_BYTES = 16;
    localparam int RFC_BEAT_W     = $clog2(RFC_LINE_BYTES) + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1
    } rfc_st_e;

    // bus bytes for a width code
    function automatic logic [2:0] rfc_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // place transfer idx (wb bytes wide) into acc, clipping at sz bytes
    function automatic logic [RFC_DATA_W-1:0] rfc_place(
        input logic [RFC_DATA_W-1:0] acc,
        input logic [RFC_DATA_W-1:0] din,
        input logic [RFC_BEAT_W-1:0] idx,
        input logic [2:0]            wb,
        input logic [2:0]            sz
    );
        logic [RFC_DATA_W-1:0] r;
        int lo;
        r  = acc;
        lo = int'(idx) * int'(wb);
        for (int b = 0; b < RFC_DATA_W / 8; b++) begin
            if (b >= lo && b < lo + int'(wb) && b < int'(sz))
                r[b*8 +: 8] = din[(b-lo)*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/rfc_cycle_len.sv
module rfc_cycle_len #(
    parameter int WAIT_W      = 3,
    parameter int PAGE_W      = 2,
    parameter int NORMAL_CLKS = 6,
    parameter int CNT_W       = 7
) (
    input  logic              fast_i,
    input  logic              page_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic [PAGE_W-1:0] pwait_i,
    output logic [CNT_W-1:0]  len_m1_o
);
    // transfer length minus one, in clocks
    always_comb begin
        if (page_i)
            len_m1_o = CNT_W'(pwait_i);
        else if (fast_i)
            len_m1_o = CNT_W'(wait_i);
        else
            len_m1_o = CNT_W'(NORMAL_CLKS - 1) + CNT_W'(wait_i);
    end
endmodule

// File: rtl/rfc_region_sel.sv
module rfc_region_sel #(
    parameter int             NREG       = 3,
    parameter int             RGN_W      = 2,
    parameter logic [NREG-1:0] REMAP_MASK = 3'b011
) (
    input  logic             active_i,
    input  logic [RGN_W-1:0] rgn_i,
    input  logic             remap_i,
    output logic [NREG-1:0]  rom_cs_n_o,
    output logic             card_cs_n_o
);
    logic [NREG-1:0] hit;
    logic [NREG-1:0] to_card;

    for (genvar r = 0; r < NREG; r++) begin : g_sel
        assign hit[r]        = active_i && (rgn_i == RGN_W'(r));
        assign to_card[r]    = hit[r] && remap_i && REMAP_MASK[r];
        assign rom_cs_n_o[r] = !(hit[r] && !to_card[r]);
    end

    assign card_cs_n_o = !(|to_card);
endmodule

// File: rtl/rom_flash_ctrl.sv
module rom_flash_ctrl
    import rfc_pkg::*;
#(
    parameter int              NREG        = 3,
    parameter int              ADDR_W      = 28,
    parameter int              WAIT_W      = 3,
    parameter int              PAGE_W      = 2,
    parameter int              NORMAL_CLKS = 6,
    parameter logic [NREG-1:0] REMAP_MASK  = 3'b011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_burst,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_data,
    input  logic [2*NREG-1:0]        cfg_width,
    input  logic [NREG-1:0]          cfg_fast,
    input  logic [WAIT_W*NREG-1:0]   cfg_wait,
    input  logic [PAGE_W-1:0]        cfg_page_wait,
    input  logic [NREG-1:0]          cfg_wp,
    input  logic                     strap_remap,
    input  logic                     sw_remap,
    output logic [NREG-1:0]          rom_cs_n,
    output logic                     card_cs_n,
    output logic                     rom_rd_n,
    output logic                     rom_wr_n,
    output logic [ADDR_W-$clog2(NREG+1)-1:0] rom_addr,
    output logic [31:0]              rom_dout,
    output logic                     rom_doe,
    input  logic [31:0]              rom_din,
    output logic                     wp_violation
);
    localparam int RGN_W  = $clog2(NREG + 1);
    localparam int OFS_W  = ADDR_W - RGN_W;
    localparam int DW     = RFC_DATA_W;
    localparam int CNT_W  = WAIT_W + 4;
    localparam int BEAT_W = RFC_BEAT_W;

    typedef struct packed {
        rfc_st_e           st;
        logic [RGN_W-1:0]  rgn;
        logic              wr;
        logic              burst;
        logic              pg;
        logic [OFS_W-1:0]  addr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     acc;
        logic [BEAT_W-1:0] idx;
        logic [BEAT_W-1:0] left;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        wb;
        logic [2:0]        sz;
        logic              rsp_v;
        logic [DW-1:0]     rsp_d;
        logic              flag;
    } ctl_t;

    ctl_t q, d;

    logic [RGN_W-1:0]  req_rgn, req_ix, sel_rgn, sel_ix;
    logic              req_mapped;
    logic [2:0]        req_wb, req_sz;
    logic              sel_fast, page_sel;
    logic [WAIT_W-1:0] sel_wait;
    logic [CNT_W-1:0]  len_m1;
    logic [DW-1:0]     acc_n;
    logic              active;

    // request decode and selection of the region whose timing applies
    always_comb begin
        req_rgn    = req_addr[ADDR_W-1 -: RGN_W];
        req_mapped = (int'(req_rgn) < NREG);
        req_ix     = req_mapped ? req_rgn : '0;
        req_wb     = rfc_bytes(cfg_width[2*req_ix +: 2]);
        case (req_size)
            2'd0:    req_sz = 3'd1;
            2'd1:    req_sz = 3'd2;
            default: req_sz = 3'd4;
        endcase
        sel_rgn  = (q.st == ST_IDLE) ? req_rgn : q.rgn;
        sel_ix   = (int'(sel_rgn) < NREG) ? sel_rgn : '0;
        sel_fast = cfg_fast[sel_ix];
        sel_wait = cfg_wait[WAIT_W*sel_ix +: WAIT_W];
        page_sel = (q.st == ST_XFER) && q.pg;
    end

    rfc_cycle_len #(
        .WAIT_W     (WAIT_W),
        .PAGE_W     (PAGE_W),
        .NORMAL_CLKS(NORMAL_CLKS),
        .CNT_W      (CNT_W)
    ) u_len (
        .fast_i  (sel_fast),
        .page_i  (page_sel),
        .wait_i  (sel_wait),
        .pwait_i (cfg_page_wait),
        .len_m1_o(len_m1)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        acc_n   = rfc_place(q.acc, rom_din, q.idx, q.wb, q.sz);
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_mapped || (req_write && cfg_wp[req_ix])) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = '0;
                        if (req_mapped) d.flag = 1'b1;
                    end else begin
                        d.st    = ST_XFER;
                        d.rgn   = req_rgn;
                        d.wr    = req_write;
                        d.burst = req_burst && !req_write;
                        d.pg    = req_burst && !req_write && cfg_fast[req_ix] && (req_wb != 3'd1);
                        d.addr  = req_addr[OFS_W-1:0];
                        d.wdata = req_wdata;
                        d.acc   = '0;
                        d.idx   = '0;
                        d.wb    = req_wb;
                        d.sz    = req_sz;
                        d.cnt   = len_m1;
                        if (req_burst && !req_write)
                            d.left = BEAT_W'(RFC_LINE_BYTES / int'(req_wb));
                        else if (req_sz > req_wb)
                            d.left = BEAT_W'(int'(req_sz) / int'(req_wb));
                        else
                            d.left = BEAT_W'(1);
                    end
                end
            end
            ST_XFER: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - CNT_W'(1);
                end else begin
                    if (q.burst) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = rfc_place('0, rom_din, '0, q.wb, q.wb);
                    end else if (!q.wr) begin
                        d.acc = acc_n;
                    end
                    if (q.left == BEAT_W'(1)) begin
                        d.st = ST_IDLE;
                        if (!q.burst) begin
                            d.rsp_v = 1'b1;
                            d.rsp_d = q.wr ? '0 : acc_n;
                        end
                    end else begin
                        d.left  = q.left - BEAT_W'(1);
                        d.idx   = q.idx + BEAT_W'(1);
                        d.addr  = q.addr + OFS_W'(q.wb);
                        d.wdata = q.wdata >> (8 * int'(q.wb));
                        d.cnt   = len_m1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = (q.st == ST_XFER);

    rfc_region_sel #(
        .NREG      (NREG),
        .RGN_W     (RGN_W),
        .REMAP_MASK(REMAP_MASK)
    ) u_sel (
        .active_i   (active),
        .rgn_i      (q.rgn),
        .remap_i    (strap_remap || sw_remap),
        .rom_cs_n_o (rom_cs_n),
        .card_cs_n_o(card_cs_n)
    );

    assign req_ready    = (q.st == ST_IDLE);
    assign rom_rd_n     = !(active && !q.wr);
    assign rom_wr_n     = !(active && q.wr);
    assign rom_doe      = active && q.wr;
    assign rom_dout     = q.wdata;
    assign rom_addr     = q.addr;
    assign rsp_valid    = q.rsp_v;
    assign rsp_data     = q.rsp_d;
    assign wp_violation = q.flag;
endmodule

// File: rtl/rom_flash_chk.sv
module rom_flash_chk #(
    parameter int              NREG       = 3,
    parameter logic [NREG-1:0] REMAP_MASK = 3'b011
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic [NREG-1:0] rom_cs_n,
    input logic            card_cs_n,
    input logic            rom_rd_n,
    input logic            rom_wr_n,
    input logic [NREG-1:0] cfg_wp,
    input logic            strap_remap,
    input logic            sw_remap,
    input logic            wp_violation
);
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_rd_n && !rom_wr_n));

    a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rom_cs_n, ~card_cs_n}));

    a_r8_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_rd_n || !rom_wr_n) |-> (!(&rom_cs_n) || !card_cs_n));

    a_r7_no_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_wr_n |-> ((~rom_cs_n & cfg_wp) == '0));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wp_violation |=> wp_violation);

    a_r9_remap_hides: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_remap || sw_remap) |-> ((rom_cs_n & REMAP_MASK) == REMAP_MASK));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rom_rd_n && rom_wr_n && (&rom_cs_n) && card_cs_n));
endmodule

bind rom_flash_ctrl rom_flash_chk #(
    .NREG      (NREG),
    .REMAP_MASK(REMAP_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rom_cs_n    (rom_cs_n),
    .card_cs_n   (card_cs_n),
    .rom_rd_n    (rom_rd_n),
    .rom_wr_n    (rom_wr_n),
    .cfg_wp      (cfg_wp),
    .strap_remap (strap_remap),
    .sw_remap    (sw_remap),
    .wp_violation(wp_violation)
);

// File: tb/sim_rom_flash_ctrl.sv
`timescale 1ns/1ps
module sim_rom_flash_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_burst;
    logic [27:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata, rsp_data, rom_dout, rom_din;
    logic        rsp_valid;
    logic [5:0]  cfg_width;
    logic [2:0]  cfg_fast, cfg_wp, rom_cs_n;
    logic [8:0]  cfg_wait;
    logic [1:0]  cfg_page_wait;
    logic        strap_remap, sw_remap, card_cs_n, rom_rd_n, rom_wr_n, rom_doe, wp_violation;
    logic [25:0] rom_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cur_wb = 4;
    logic [7:0] wmem [64];

    always #2.5 clk = ~clk;

    rom_flash_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_burst(req_burst), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cfg_width(cfg_width), .cfg_fast(cfg_fast),
        .cfg_wait(cfg_wait), .cfg_page_wait(cfg_page_wait), .cfg_wp(cfg_wp),
        .strap_remap(strap_remap), .sw_remap(sw_remap), .rom_cs_n(rom_cs_n),
        .card_cs_n(card_cs_n), .rom_rd_n(rom_rd_n), .rom_wr_n(rom_wr_n),
        .rom_addr(rom_addr), .rom_dout(rom_dout), .rom_doe(rom_doe),
        .rom_din(rom_din), .wp_violation(wp_violation)
    );

    function automatic logic [7:0] fb(input int a);
        return 8'(a) ^ 8'hC3;
    endfunction

    function automatic logic [31:0] exp_rd(input int a, input int n);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < n; k++) r[k*8 +: 8] = fb(a + k);
        return r;
    endfunction

    // external memory model: read lanes from address, capture write lanes
    always_comb begin
        rom_din = '1;
        if (!rom_rd_n)
            for (int k = 0; k < 4; k++) rom_din[k*8 +: 8] = fb(int'(rom_addr) + k);
    end

    always @(negedge clk) begin
        if (!rom_wr_n)
            for (int k = 0; k < cur_wb; k++)
                wmem[(int'(rom_addr) + k) % 64] <= rom_dout[k*8 +: 8];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit sel_ok(input int rgn);
        if ((strap_remap || sw_remap) && rgn < 2)
            return (rom_cs_n == 3'b111) && !card_cs_n;
        return (rom_cs_n == ~(3'b001 << rgn)) && card_cs_n;
    endfunction

    task automatic access(input logic wr, input int rgn, input logic [1:0] size,
                          input logic burst, input int ofs, input logic [31:0] wd,
                          input int exp_edges, input int exp_pulses, input int exp_strobes,
                          input string req);
        int sz, wb, pulses, strobes, edges, bad;
        logic [31:0] exp, act;
        sz = 1 << size;
        wb = (rgn == 0) ? 1 : (rgn == 1) ? 2 : 4;
        cur_wb = wb;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = size; req_burst = burst;
        req_addr = {2'(rgn), 26'(ofs)}; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        edges = 0; pulses = 0; strobes = 0; bad = 0;
        if (exp_strobes > 0) chk(!req_ready, "R10", "ready during access", 32'(req_ready), 0);
        forever begin
            if (!rom_rd_n || !rom_wr_n) begin
                strobes++;
                if (!sel_ok(rgn)) bad++;
                if (wr && (!rom_rd_n || !rom_doe)) bad++;
                if (!wr && (!rom_wr_n || rom_doe)) bad++;
            end
            if (rsp_valid) begin
                if (burst && !wr && rgn < 3) exp = exp_rd(ofs + pulses * wb, wb);
                else if (wr || rgn == 3) exp = '0;
                else exp = exp_rd(ofs, sz);
                chk(rsp_data == exp, req, "response data", rsp_data, exp);
                pulses++;
            end
            if (pulses >= exp_pulses || edges > 300) break;
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        chk(edges == exp_edges, req, "edges to last response", 32'(edges), 32'(exp_edges));
        chk(strobes == exp_strobes, req, "strobe cycles", 32'(strobes), 32'(exp_strobes));
        chk(bad == 0, {req, " R8"}, "select/strobe kind errors", 32'(bad), 0);
        if (wr && exp_strobes > 0) begin
            act = '0;
            for (int k = 0; k < sz; k++) act[k*8 +: 8] = wmem[(ofs + k) % 64];
            exp = wd & ((sz == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * sz)) - 1));
            chk(act == exp, {req, " R8"}, "bytes written", act, exp);
        end
        @(negedge clk);
        chk(!rsp_valid, "R10", "response pulse width", 32'(rsp_valid), 0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  rgn;
        logic [1:0]  size;
        logic        burst;
        logic [7:0]  ofs;
        logic [31:0] wdata;
        logic [7:0]  edges;
        logic [4:0]  pulses;
    } vec_t;

    // config: r0 8-bit slow wait1, r1 16-bit fast wait2, r2 32-bit fast wait1, page wait 0
    localparam vec_t VEC [14] = '{
        '{1'b0, 2'd0, 2'd0, 1'b0, 8'd8,  32'h0,         8'd7,   5'd1},
        '{1'b0, 2'd0, 2'd2, 1'b0, 8'd12, 32'h0,         8'd28,  5'd1},
        '{1'b0, 2'd1, 2'd1, 1'b0, 8'd20, 32'h0,         8'd3,   5'd1},
        '{1'b0, 2'd1, 2'd2, 1'b0, 8'd24, 32'h0,         8'd6,   5'd1},
        '{1'b0, 2'd2, 2'd2, 1'b0, 8'd32, 32'h0,         8'd2,   5'd1},
        '{1'b0, 2'd2, 2'd0, 1'b0, 8'd40, 32'h0,         8'd2,   5'd1},
        '{1'b1, 2'd0, 2'd1, 1'b0, 8'd4,  32'h0000_BEEF, 8'd14,  5'd1},
        '{1'b1, 2'd1, 2'd2, 1'b0, 8'd16, 32'h1234_5678, 8'd6,   5'd1},
        '{1'b1, 2'd2, 2'd2, 1'b0, 8'd44, 32'hCAFE_F00D, 8'd2,   5'd1},
        '{1'b0, 2'd2, 2'd2, 1'b1, 8'd48, 32'h0,         8'd5,   5'd4},
        '{1'b0, 2'd1, 2'd2, 1'b1, 8'd0,  32'h0,         8'd10,  5'd8},
        '{1'b0, 2'd0, 2'd2, 1'b1, 8'd16, 32'h0,         8'd112, 5'd16},
        '{1'b1, 2'd2, 2'd2, 1'b1, 8'd52, 32'hA1B2_C3D4, 8'd2,   5'd1},
        '{1'b0, 2'd1, 2'd0, 1'b0, 8'd3,  32'h0,         8'd3,   5'd1}
    };
    localparam string VTAG [14] = '{"R2 R3", "R2 R3", "R2 R4", "R2 R4", "R1 R4", "R2 R4",
        "R2 R3", "R2 R4", "R4", "R5", "R5", "R6", "R5", "R2"};

    bit done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
        req_addr = '0; req_size = '0; req_wdata = '0;
        cfg_width = {2'd2, 2'd1, 2'd0}; cfg_fast = 3'b110; cfg_wait = {3'd1, 3'd2, 3'd1};
        cfg_page_wait = 2'd0; cfg_wp = 3'b000; strap_remap = 1'b0; sw_remap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready, "R11", "ready", 32'(req_ready), 1);
        chk(rom_rd_n && rom_wr_n, "R11", "strobes", {30'd0, rom_rd_n, rom_wr_n}, 3);
        chk(rom_cs_n == 3'b111 && card_cs_n, "R11", "selects", {28'd0, card_cs_n, rom_cs_n}, 15);
        chk(!rsp_valid && !wp_violation, "R11", "rsp/flag", {30'd0, rsp_valid, wp_violation}, 0);

        foreach (VEC[i])
            access(VEC[i].wr, int'(VEC[i].rgn), VEC[i].size, VEC[i].burst, int'(VEC[i].ofs),
                   VEC[i].wdata, int'(VEC[i].edges), int'(VEC[i].pulses),
                   int'(VEC[i].edges), VTAG[i]);

        // R7 protected write, reads still allowed, flag sticky
        cfg_wp = 3'b010;
        access(1'b1, 1, 2'd1, 1'b0, 8, 32'h0000_5555, 0, 1, 0, "R7");
        chk(wp_violation, "R7", "flag after protected write", 32'(wp_violation), 1);
        access(1'b0, 1, 2'd1, 1'b0, 8, 32'h0, 3, 1, 3, "R7");
        chk(wp_violation, "R7", "flag still set", 32'(wp_violation), 1);
        // R1 unmapped region
        access(1'b0, 3, 2'd2, 1'b0, 0, 32'h0, 0, 1, 0, "R1");
        cfg_wp = 3'b000;

        // R9 remap via control bit then strap
        sw_remap = 1'b1;
        access(1'b0, 0, 2'd0, 1'b0, 5, 32'h0, 7, 1, 7, "R9");
        access(1'b0, 2, 2'd2, 1'b0, 8, 32'h0, 2, 1, 2, "R9");
        sw_remap = 1'b0; strap_remap = 1'b1;
        access(1'b0, 1, 2'd1, 1'b0, 10, 32'h0, 3, 1, 3, "R9");
        strap_remap = 1'b0;

        // zero wait boundaries and page wait
        cfg_wait = {3'd0, 3'd2, 3'd0}; cfg_page_wait = 2'd2;
        access(1'b0, 2, 2'd2, 1'b0, 36, 32'h0, 1, 1, 1, "R4");
        access(1'b0, 0, 2'd0, 1'b0, 9, 32'h0, 6, 1, 6, "R3");
        access(1'b0, 2, 2'd2, 1'b1, 16, 32'h0, 10, 4, 10, "R5");

        // R7 flag clears only by reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!wp_violation, "R7", "flag after reset", 32'(wp_violation), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule